// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits in a host bridge and turns host accesses into configuration cycles. The host sees two windows. The index window holds a 32-bit configuration address word. The data window starts one configuration cycle per access. The translation uses the held word together with the low three bits of the data-window offset, and it produces a conventional bus/device/function/register address.

The held word can take three forms:
- **Passthrough.** Bit 31 is set. The word is used as-is, with the offset's two lowest bits ORed in.
- **Type-1.** Bit 31 is clear and bit 0 is set. The three lowest bits of the word are replaced by the offset.
- **IDSEL (type-0).** Both flags are clear. Bits [31:11] form a one-hot device select, and the position of the lowest set bit becomes the slot number.

The block sends one request at a time to the bus side and waits for that side's response before it completes the host access. A small router also maps each slot's four interrupt pins onto four shared interrupt lines, rotating them by device number.

The block decodes only the three lowest offset bits. Window decoding and aliasing across each 4 KiB window are done upstream. Data lanes are little-endian: byte lane n is bits [8n+7:8n].

Top module: `cfgx_bridge`

## Requirements
- R1: After reset the index word reads as zero, no request is pending, `host_done`/`host_err` are low, and no interrupt line is active without a pin asserted.
- R2: An index-window access completes with a one-cycle `host_done` in the cycle after acceptance. A write updates only the enabled byte lanes of the index word. A read returns the whole word.
- R3: When index bit 31 is set, the cycle address is the index word ORed with offset bits [1:0].
- R4: When bit 31 is clear and bit 0 is set, the cycle address is index bits [31:3] followed by offset bits [2:0].
- R5: When bits 31 and 0 are both clear, the cycle address is built from four fields: (slot << 11), index bits [10:8] at [10:8], index bits [7:3] at [7:3], and offset [2:0] at [2:0]. The slot is the position of the lowest set bit in index bits [31:11].
- R6: In the mode of R5, when no bit of index [31:11] is set, the slot is all ones, so address bits [31:11] are all ones.
- R7: `host_size` gives the byte count: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. `cfg_be` is the matching contiguous mask shifted left by offset [1:0], and `cfg_size` carries the code unchanged.
- R8: An access with size code 3, or one that would cross a dword (offset[1:0] plus byte count greater than 4), completes with `host_err` high. It issues no cycle and does not change the index word.
- R9: Only one request is outstanding at a time. `cfg_req_valid` and its fields stay steady until `cfg_rsp_valid`. `host_done` follows in the next cycle, and a read returns `cfg_rsp_rdata` on `host_rdata`.
- R10: A data-window write issues a request with `cfg_wr` high and `host_wdata` on `cfg_wdata`. A read issues one with `cfg_wr` low.
- R11: Pin p of slot s, at bit 4s+p of `irq_pin_lvl`, drives `irq_line[(p + FIRST_DEV + s) mod 4]`. With the default FIRST_DEV of 11, slot 0 INTA drives line 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request, held until `host_done` |
| host_win | input | 1 | 0 = index window, 1 = data window |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Low offset bits within the window |
| host_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| host_wdata | input | 32 | Write data, lane-aligned |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Access rejected (valid with `host_done`) |
| host_rdata | output | 32 | Read data (valid with `host_done`) |
| cfg_req_valid | output | 1 | Configuration cycle request pending |
| cfg_wr | output | 1 | Cycle direction |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_size | output | 2 | Size code of the cycle |
| cfg_wdata | output | 32 | Write data of the cycle |
| cfg_rsp_valid | input | 1 | Bus side has finished the cycle |
| cfg_rsp_rdata | input | 32 | Read data from the bus side |
| irq_pin_lvl | input | 16 | Per-slot interrupt pin levels, bit 4s+p |
| irq_line | output | 4 | Shared interrupt lines |

## Verification
The translation table exercises each mode with words designed to separate it from the others:
- **Passthrough.** Words with bit 31 set and with bit 0 also set confirm that bit 31 takes priority, and that offset bit 2 is dropped.
- **Type-1.** Words with garbage in bits [2:0] confirm that the offset replaces those bits rather than ORing into them.
- **IDSEL.** Words with a single select bit, with several select bits (the lowest must win), and with none (the all-ones slot) are used. These are combined with nonzero function and register fields and with a set index bit 2, which must not leak through.

Directed accesses then separate legal from dword-crossing byte-enable shapes. They also check partial index writes and check the read data against the write path. Each slot/pin pair is driven alone to expose any wrong rotation.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } cfgx_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } cfgx_state_e;

  localparam int unsigned IDSEL_LO = 11;

  // Position of the lowest set bit in [31:IDSEL_LO]; 32 when none is set.
  function automatic logic [5:0] cfgx_idsel_slot(input logic [31:0] w);
    logic [5:0] n;
    n = 6'd32;
    for (int i = 31; i >= IDSEL_LO; i--) begin
      if (w[i]) n = 6'(i);
    end
    return n;
  endfunction

  function automatic logic [31:0] cfgx_translate(input logic [31:0] idx,
                                                 input logic [2:0]  off);
    logic [31:0] slot_w;
    logic [5:0]  slot;
    if (idx[31]) begin
      return idx | {30'd0, off[1:0]};
    end else if (idx[0]) begin
      return {idx[31:3], off};
    end
    slot   = cfgx_idsel_slot(idx);
    slot_w = (slot == 6'd32) ? '1 : {26'd0, slot};
    return (slot_w << IDSEL_LO) | {21'd0, idx[10:8], idx[7:3], off};
  endfunction

  function automatic logic cfgx_fits(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_B1:   return 1'b1;
      SZ_B2:   return lo != 2'd3;
      SZ_B4:   return lo == 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] cfgx_byte_en(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_B1:   return 4'(4'b0001 << lo);
      SZ_B2:   return 4'(4'b0011 << lo);
      SZ_B4:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int unsigned cfgx_size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_B1:   return 1;
      SZ_B2:   return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int unsigned cfgx_irq_route(input int unsigned pin,
                                                 input int unsigned dev,
                                                 input int unsigned lines);
    return (pin + dev) % lines;
  endfunction

endpackage

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NBYTE = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NBYTE-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                q[8*b +: 8] <= 8'd0;
      else if (wr_en && be[b])   q[8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  p_index_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q))
    else $error("index word changed without a write");
endmodule

// File: rtl/cfgx_addr_map.sv
module cfgx_addr_map
  import cfgx_pkg::*;
(
  input  logic [31:0] idx,
  input  logic [2:0]  off,
  output logic [31:0] xl_addr,
  output logic        no_idsel
);
  always_comb begin
    xl_addr  = cfgx_translate(idx, off);
    no_idsel = !idx[31] && !idx[0] && (cfgx_idsel_slot(idx) == 6'd32);
  end
endmodule

// File: rtl/cfgx_cycle_ctl.sv
module cfgx_cycle_ctl
  import cfgx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NBYTE = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_win,
  input  logic              host_wr,
  input  logic [2:0]        host_off,
  input  logic [1:0]        host_size,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] idx_q,
  input  logic [31:0]       xl_addr,
  output logic              idx_wr_en,
  output logic [NBYTE-1:0]  idx_be,
  output logic              host_done,
  output logic              host_err,
  output logic [DATA_W-1:0] host_rdata,
  output logic              cfg_req_valid,
  output logic              cfg_wr,
  output logic [31:0]       cfg_addr,
  output logic [NBYTE-1:0]  cfg_be,
  output logic [1:0]        cfg_size,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [DATA_W-1:0] cfg_rsp_rdata
);
  cfgx_state_e state;
  logic        accept;
  logic        fits;
  logic [3:0]  be_w;

  always_comb begin
    accept    = (state == ST_IDLE) && host_valid;
    fits      = cfgx_fits(host_size, host_off[1:0]);
    be_w      = cfgx_byte_en(host_size, host_off[1:0]);
    idx_wr_en = accept && !host_win && host_wr && fits;
    idx_be    = be_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      host_done     <= 1'b0;
      host_err      <= 1'b0;
      host_rdata    <= '0;
      cfg_req_valid <= 1'b0;
      cfg_wr        <= 1'b0;
      cfg_addr      <= '0;
      cfg_be        <= '0;
      cfg_size      <= '0;
      cfg_wdata     <= '0;
    end else begin
      host_done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (!fits) begin
            host_err  <= 1'b1;
            host_done <= 1'b1;
            state     <= ST_DONE;
          end else if (!host_win) begin
            host_err  <= 1'b0;
            host_done <= 1'b1;
            if (!host_wr) host_rdata <= idx_q;
            state     <= ST_DONE;
          end else begin
            host_err      <= 1'b0;
            cfg_req_valid <= 1'b1;
            cfg_wr        <= host_wr;
            cfg_addr      <= xl_addr;
            cfg_be        <= be_w;
            cfg_size      <= host_size;
            cfg_wdata     <= host_wdata;
            state         <= ST_WAIT;
          end
        end
        ST_WAIT: if (cfg_rsp_valid) begin
          cfg_req_valid <= 1'b0;
          host_done     <= 1'b1;
          if (!cfg_wr) host_rdata <= cfg_rsp_rdata;
          state         <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_rsp_valid |=> cfg_req_valid && $stable(cfg_addr) && $stable(cfg_be)
      && $stable(cfg_wdata))
    else $error("request fields moved while outstanding");

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done)
    else $error("host_done longer than one cycle");

  p_err_no_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_done && host_err |-> !cfg_req_valid && !$past(cfg_req_valid))
    else $error("rejected access produced a cycle");

  p_be_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> $countones(cfg_be) == cfgx_size_bytes(cfg_size))
    else $error("byte enables do not match size");
endmodule

// File: rtl/cfgx_irq_route.sv
module cfgx_irq_route
  import cfgx_pkg::*;
#(
  parameter int unsigned NUM_SLOT  = 4,
  parameter int unsigned FIRST_DEV = 11,
  parameter int unsigned NUM_LINE  = 4,
  localparam int unsigned NUM_PIN  = 4
) (
  input  logic [NUM_SLOT*NUM_PIN-1:0] pin_lvl,
  output logic [NUM_LINE-1:0]         line
);
  always_comb begin
    line = '0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      for (int p = 0; p < NUM_PIN; p++) begin
        line[cfgx_irq_route(p, FIRST_DEV + s, NUM_LINE)] =
          line[cfgx_irq_route(p, FIRST_DEV + s, NUM_LINE)] | pin_lvl[s*NUM_PIN + p];
      end
    end
  end

  always_comb begin
    p_irq_quiet_r11: assert ((|pin_lvl) || (line == '0))
      else $error("interrupt line active with no pin asserted");
  end
endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
  import cfgx_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_SLOT  = 4,
  parameter int unsigned FIRST_DEV = 11,
  localparam int unsigned NBYTE    = DATA_W / 8,
  localparam int unsigned NUM_LINE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_valid,
  input  logic                  host_win,
  input  logic                  host_wr,
  input  logic [2:0]            host_off,
  input  logic [1:0]            host_size,
  input  logic [DATA_W-1:0]     host_wdata,
  output logic                  host_done,
  output logic                  host_err,
  output logic [DATA_W-1:0]     host_rdata,
  output logic                  cfg_req_valid,
  output logic                  cfg_wr,
  output logic [31:0]           cfg_addr,
  output logic [NBYTE-1:0]      cfg_be,
  output logic [1:0]            cfg_size,
  output logic [DATA_W-1:0]     cfg_wdata,
  input  logic                  cfg_rsp_valid,
  input  logic [DATA_W-1:0]     cfg_rsp_rdata,
  input  logic [NUM_SLOT*4-1:0] irq_pin_lvl,
  output logic [NUM_LINE-1:0]   irq_line
);
  logic [DATA_W-1:0] idx_q;
  logic              idx_wr_en;
  logic [NBYTE-1:0]  idx_be;
  logic [31:0]       xl_addr;
  logic              no_idsel;

  cfgx_index_reg #(.DATA_W(DATA_W)) u_index (
    .clk(clk), .rst_n(rst_n), .wr_en(idx_wr_en), .be(idx_be),
    .wdata(host_wdata), .q(idx_q)
  );

  cfgx_addr_map u_map (
    .idx(idx_q[31:0]), .off(host_off), .xl_addr(xl_addr), .no_idsel(no_idsel)
  );

  cfgx_cycle_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_win(host_win), .host_wr(host_wr),
    .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
    .idx_q(idx_q), .xl_addr(xl_addr),
    .idx_wr_en(idx_wr_en), .idx_be(idx_be),
    .host_done(host_done), .host_err(host_err), .host_rdata(host_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata)
  );

  cfgx_irq_route #(.NUM_SLOT(NUM_SLOT), .FIRST_DEV(FIRST_DEV), .NUM_LINE(NUM_LINE)) u_irq (
    .pin_lvl(irq_pin_lvl), .line(irq_line)
  );

  // Non-passthrough modes put the offset verbatim into the low three bits (R4, R5).
  p_lowbits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_valid) && !idx_q[31] |-> cfg_addr[2:0] == $past(host_off))
    else $error("offset bits not carried into cycle address");

  // A type-0 word with no select bit yields all-ones upper address (R6).
  p_noidsel_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_valid) && $past(no_idsel) |-> cfg_addr[31:11] == '1)
    else $error("missing select bit did not fill upper address");
endmodule

// File: tb/cfgx_bridge_tb.sv
module cfgx_bridge_tb;
  localparam int LAT = 2;
  localparam int NV  = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_win = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_off = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_done, host_err;
  logic [31:0] host_rdata;
  logic        cfg_req_valid, cfg_wr;
  logic [31:0] cfg_addr, cfg_wdata;
  logic [3:0]  cfg_be;
  logic [1:0]  cfg_size;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;
  logic [15:0] irq_pin_lvl = '0;
  logic [3:0]  irq_line;

  int n_chk = 0, n_fail = 0;
  int req_count = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_be;
  logic        cap_wr;
  logic [1:0]  cap_size;
  logic        cap_moved;

  always #5 clk = ~clk;

  cfgx_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_win(host_win),
    .host_wr(host_wr), .host_off(host_off), .host_size(host_size),
    .host_wdata(host_wdata), .host_done(host_done), .host_err(host_err),
    .host_rdata(host_rdata), .cfg_req_valid(cfg_req_valid), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_rsp_valid(cfg_rsp_valid),
    .cfg_rsp_rdata(cfg_rsp_rdata), .irq_pin_lvl(irq_pin_lvl), .irq_line(irq_line)
  );

  // idx[66:35], off[34:32], expected address[31:0]
  localparam logic [66:0] VEC [0:NV-1] = '{
    {32'h8000_0000, 3'd3, 32'h8000_0003},  // R3
    {32'h8001_2344, 3'd2, 32'h8001_2346},  // R3
    {32'h8000_0001, 3'd6, 32'h8000_0003},  // R3 bit31 beats bit0, off bit2 dropped
    {32'h0012_3455, 3'd6, 32'h0012_3456},  // R4
    {32'h00AB_CD0F, 3'd5, 32'h00AB_CD0D},  // R4
    {32'h7FFF_FFFF, 3'd2, 32'h7FFF_FFFA},  // R4
    {32'h0000_0800, 3'd1, 32'h0000_5801},  // R5 slot 11
    {32'h0001_0324, 3'd7, 32'h0000_8327},  // R5 slot 16, fn 3, reg 0x20
    {32'h4000_1800, 3'd0, 32'h0000_5800},  // R5 lowest select wins
    {32'h4000_0000, 3'd0, 32'h0000_F000},  // R5 slot 30
    {32'h0000_0000, 3'd4, 32'hFFFF_F804},  // R6
    {32'h0000_07FE, 3'd3, 32'hFFFF_FFFB}   // R6 with fn/reg fields
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic win, input logic wr, input logic [2:0] off,
                        input logic [1:0] sz, input logic [31:0] wd,
                        output logic [31:0] rd, output logic err, output int waits);
    @(negedge clk);
    host_valid = 1'b1; host_win = win; host_wr = wr; host_off = off;
    host_size = sz; host_wdata = wd;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!host_done);
    rd = host_rdata; err = host_err;
    host_valid = 1'b0;
  endtask

  // Bus-side responder: answers each request after LAT cycles.
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (cfg_rsp_valid) begin
        cfg_rsp_valid = 1'b0;
      end else if (cfg_req_valid) begin
        if (lat == 0) begin
          cap_addr = cfg_addr; cap_be = cfg_be; cap_wr = cfg_wr;
          cap_wdata = cfg_wdata; cap_size = cfg_size; cap_moved = 1'b0;
        end else if (cfg_addr != cap_addr || cfg_be != cap_be) begin
          cap_moved = 1'b1;
        end
        if (lat == LAT) begin
          cfg_rsp_valid = 1'b1;
          cfg_rsp_rdata = cfg_addr ^ 32'h5A5A_5A5A;
          req_count++;
          lat = 0;
        end else begin
          lat++;
        end
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        err;
    int          w;
    int          rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(!cfg_req_valid && !host_done && !host_err, "R1 idle", {29'd0, cfg_req_valid, host_done, host_err}, 32'd0);
    check(irq_line == 4'd0, "R1 irq", {28'd0, irq_line}, 32'd0);
    access(1'b0, 1'b0, 3'd0, 2'd2, 32'd0, rd, err, w);
    check(rd == 32'd0, "R1 index", rd, 32'd0);
    check(w == 1 && !err, "R2 done timing", w, 32'd1);

    // Vector table: modes R3..R6
    for (int i = 0; i < NV; i++) begin
      access(1'b0, 1'b1, 3'd0, 2'd2, VEC[i][66:35], rd, err, w);
      access(1'b1, 1'b0, VEC[i][34:32], 2'd0, 32'd0, rd, err, w);
      check(cap_addr == VEC[i][31:0], "R3/R4/R5/R6 addr", cap_addr, VEC[i][31:0]);
      check(rd == (VEC[i][31:0] ^ 32'h5A5A_5A5A), "R9 rdata", rd, VEC[i][31:0] ^ 32'h5A5A_5A5A);
    end

    // R2: partial index write touches byte lane 2 only
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'hFFFF_FFFF, rd, err, w);
    access(1'b0, 1'b1, 3'd2, 2'd0, 32'h00AA_0000, rd, err, w);
    access(1'b0, 1'b0, 3'd0, 2'd2, 32'd0, rd, err, w);
    check(rd == 32'hFFAA_FFFF, "R2 byte write", rd, 32'hFFAA_FFFF);

    // R7, R10: 2-byte write at offset 2 (index passthrough 0xFFAAFFFF)
    access(1'b1, 1'b1, 3'd2, 2'd1, 32'h1234_0000, rd, err, w);
    check(cap_be == 4'b1100, "R7 be", {28'd0, cap_be}, 32'hC);
    check(cap_size == 2'd1, "R7 size", {30'd0, cap_size}, 32'd1);
    check(cap_wr && cap_wdata == 32'h1234_0000, "R10 write data", cap_wdata, 32'h1234_0000);
    check(!err && w == LAT + 2, "R9 latency", w, LAT + 2);
    check(!cap_moved, "R9 held", {31'd0, cap_moved}, 32'd0);
    access(1'b1, 1'b1, 3'd1, 2'd0, 32'h0000_3300, rd, err, w);
    check(cap_be == 4'b0010, "R7 be byte1", {28'd0, cap_be}, 32'h2);
    access(1'b1, 1'b0, 3'd4, 2'd2, 32'd0, rd, err, w);
    check(cap_be == 4'b1111 && !cap_wr, "R10 read", {27'd0, cap_wr, cap_be}, 32'hF);

    // R8: rejected accesses
    rc = req_count;
    access(1'b1, 1'b0, 3'd3, 2'd1, 32'd0, rd, err, w);
    check(err, "R8 cross err", {31'd0, err}, 32'd1);
    access(1'b1, 1'b1, 3'd0, 2'd3, 32'd0, rd, err, w);
    check(err, "R8 bad size err", {31'd0, err}, 32'd1);
    access(1'b1, 1'b0, 3'd2, 2'd2, 32'd0, rd, err, w);
    check(err && req_count == rc, "R8 no cycle", req_count, rc);
    access(1'b0, 1'b1, 3'd1, 2'd2, 32'h0, rd, err, w);
    check(err, "R8 index err", {31'd0, err}, 32'd1);
    access(1'b0, 1'b0, 3'd0, 2'd2, 32'd0, rd, err, w);
    check(rd == 32'hFFAA_FFFF && !err, "R8 index kept", rd, 32'hFFAA_FFFF);

    // R11: each slot/pin alone
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        irq_pin_lvl = 16'(1) << (s*4 + p);
        #1;
        check(irq_line == 4'(1 << ((p + 11 + s) % 4)), "R11 route",
              {28'd0, irq_line}, {28'd0, 4'(1 << ((p + 11 + s) % 4))});
      end
    end
    irq_pin_lvl = '0;
    #1;
    check(irq_line == 4'd0, "R11 quiet", {28'd0, irq_line}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule